// File: doc/BRIEF.md
# Bit-Serial Square-Array Memory

This block stores sixteen single bits. To the outside it looks like a plain 16-word by 1-bit memory. Inside, the bits sit in a square grid of four rows and four columns. The two least significant address bits drive a one-hot row decoder that picks one row line. The two most significant address bits steer a column selector. On a read, the selector works as a 4:1 multiplexer over the four bit lines of the active row. On a write, it works as a 1:4 demultiplexer that enables exactly one cell in that row.

All three control strobes are active low: chip select, output enable and write enable. A system clock samples them. The bidirectional data pin is split into a data input, a data output and a drive-enable output. A pad ring or the surrounding fabric is expected to join these into one tristate pin. A write does not happen while write enable is held low. It happens when the sampled write enable goes back from low to high, and it stores the data input present at that moment.

A status output flags an address that moves during a write pulse. This breaks the memory's timing protocol, and the flag lets surrounding logic or a bench detect it.

Top module: `cell_grid_mem`

## Requirements
- R1: A synchronous reset clears all sixteen cells to 0, and the drive-enable output is 0 while no read is requested.
- R2: Address bits [1:0] select the row: exactly one row line is active at any time, and it is the line numbered by those bits.
- R3: Address bits [3:2] select the column within the active row, for both reads and writes, so that each of the sixteen addresses maps to its own cell.
- R4: While chip select (active low) is high, the block neither reads nor writes. A write pulse that chip select leaves before write enable returns high stores nothing.
- R5: The drive-enable output is 1 only while chip select and output enable (both active low) are low and write enable is high. Otherwise it is 0 and the data output reads 0.
- R6: A write commits at the first clock edge where write enable is sampled high after being sampled low with chip select low. It stores the data input and uses the address present at that edge, and the value can be read one cycle later.
- R7: While write enable and output enable are both low, the write takes priority: the drive-enable output stays 0.
- R8: The fault output is 1 exactly in a cycle where a write pulse was active in both the previous and the current cycle and the address differs from the previous cycle.
- R9: A read returns the stored bit of the addressed cell on the data output in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip select, active low |
| rd_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low; the write commits on its rise |
| addr | input | 4 | Word address: bits [1:0] row, bits [3:2] column |
| din | input | 1 | Data input half of the bidirectional pin |
| dout | output | 1 | Data output half of the pin, 0 when not driven |
| dout_oe | output | 1 | Drive enable for the tristate pin |
| addr_fault | output | 1 | Address changed during an active write pulse |

## Verification
The bench fills the grid with several patterns and reads back every address after each fill:
- All ones.
- Overall address parity, which forms a checkerboard across rows and columns.
- A pattern that depends only on the row bit.
- A pattern that depends only on the column bit.

The row-only and column-only fills show whether the row and column halves of the address have been swapped or dropped. A walking single one over all sixteen positions exposes any two addresses that share a cell. Separate sequences cover the following cases:
- A data input that changes in the middle of a pulse, to prove that the value at the rising edge is the one stored.
- A pulse aborted by releasing chip select.
- Output enable and write enable held low together.
- An address that moves during a pulse, compared with one that stays put.

// File: rtl/cgm_pkg.sv
package cgm_pkg;

  // Row number carried by the low address bits.
  function automatic int unsigned row_of(int unsigned a, int unsigned row_bits);
    return a % (32'd1 << row_bits);
  endfunction

  // Column number carried by the high address bits.
  function automatic int unsigned col_of(int unsigned a, int unsigned row_bits);
    return a >> row_bits;
  endfunction

  // Flat storage slot of a word: rows are laid out one after another.
  function automatic int unsigned slot_of(int unsigned a, int unsigned row_bits,
                                          int unsigned col_bits);
    return row_of(a, row_bits) * (32'd1 << col_bits) + col_of(a, row_bits);
  endfunction

endpackage

// File: rtl/cgm_row_decoder.sv
module cgm_row_decoder #(
  parameter int ROW_BITS = 2,
  localparam int ROWS = 1 << ROW_BITS
) (
  input  logic [ROW_BITS-1:0] row_sel,
  output logic [ROWS-1:0]     row_line
);
  for (genvar r = 0; r < ROWS; r++) begin : g_line
    assign row_line[r] = (row_sel == ROW_BITS'(r));
  end
endmodule

// File: rtl/cgm_column_path.sv
module cgm_column_path #(
  parameter int COL_BITS = 2,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic [COL_BITS-1:0] col_sel,
  input  logic [COLS-1:0]     bit_lines,
  input  logic                wr_go,
  output logic                rd_bit,
  output logic [COLS-1:0]     col_wr
);
  // Read side: pick one bit line.
  assign rd_bit = bit_lines[col_sel];

  // Write side: route the commit strobe to one column.
  for (genvar c = 0; c < COLS; c++) begin : g_demux
    assign col_wr[c] = wr_go && (col_sel == COL_BITS'(c));
  end
endmodule

// File: rtl/cgm_cell_array.sv
module cgm_cell_array #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ROWS  = 1 << ROW_BITS,
  localparam int COLS  = 1 << COL_BITS,
  localparam int CELLS = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROWS-1:0]  row_line,
  input  logic [COLS-1:0]  col_wr,
  input  logic             wr_bit,
  output logic [COLS-1:0]  bit_lines,
  output logic [CELLS-1:0] cells
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] row_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        row_q <= '0;
      end else if (row_line[r]) begin
        for (int c = 0; c < COLS; c++) begin
          if (col_wr[c]) row_q[c] <= wr_bit;
        end
      end
    end
    assign cells[r*COLS +: COLS] = row_q;
  end

  // Bit lines carry the cells of whichever row is active.
  always_comb begin
    bit_lines = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_line[r]) bit_lines = bit_lines | cells[r*COLS +: COLS];
    end
  end
endmodule

// File: rtl/cgm_strobe_tracker.sv
module cgm_strobe_tracker #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              pulse_now,
  output logic              commit,
  output logic              addr_fault
);
  logic              pulse_q;
  logic [ADDR_W-1:0] addr_q;

  assign pulse_now = !sel_n && !wr_en_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      pulse_q <= pulse_now;
      addr_q  <= addr;
    end
  end

  // Rising edge of the sampled strobe, while the chip stays selected.
  assign commit     = pulse_q && !sel_n && wr_en_n;
  assign addr_fault = pulse_q && pulse_now && (addr != addr_q);
endmodule

// File: rtl/cell_grid_mem.sv
module cell_grid_mem #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS   = 1 << ROW_BITS,
  localparam int COLS   = 1 << COL_BITS,
  localparam int CELLS  = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              rd_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic              addr_fault
);
  logic [ROWS-1:0]  row_line;
  logic [COLS-1:0]  col_wr;
  logic [COLS-1:0]  bit_lines;
  logic [CELLS-1:0] cells;
  logic             rd_bit;
  logic             pulse_now;
  logic             commit;

  cgm_strobe_tracker #(.ADDR_W(ADDR_W)) u_strobe (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_en_n(wr_en_n), .addr(addr),
    .pulse_now(pulse_now), .commit(commit), .addr_fault(addr_fault)
  );

  cgm_row_decoder #(.ROW_BITS(ROW_BITS)) u_rows (
    .row_sel(addr[ROW_BITS-1:0]), .row_line(row_line)
  );

  cgm_column_path #(.COL_BITS(COL_BITS)) u_cols (
    .col_sel(addr[ADDR_W-1:ROW_BITS]), .bit_lines(bit_lines), .wr_go(commit),
    .rd_bit(rd_bit), .col_wr(col_wr)
  );

  cgm_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_array (
    .clk(clk), .rst(rst), .row_line(row_line), .col_wr(col_wr), .wr_bit(din),
    .bit_lines(bit_lines), .cells(cells)
  );

  // Read gating: a held write enable blocks the output driver.
  assign dout_oe = !sel_n && !rd_en_n && wr_en_n;
  assign dout    = dout_oe && rd_bit;
endmodule

// File: rtl/cgm_checker.sv
module cgm_checker #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS   = 1 << ROW_BITS,
  localparam int CELLS  = ROWS * (1 << COL_BITS)
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              rd_en_n,
  input logic              wr_en_n,
  input logic [ADDR_W-1:0] addr,
  input logic              din,
  input logic              dout_oe,
  input logic              addr_fault,
  input logic              commit,
  input logic [ROWS-1:0]   row_line,
  input logic [CELLS-1:0]  cells
);
  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(row_line) == 1); // R2
  AST_ROW_FROM_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    row_line[addr[ROW_BITS-1:0]]); // R2
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    sel_n |-> (!commit && !dout_oe)); // R4
  AST_DRIVE_GATING: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> (!sel_n && !rd_en_n)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_en_n) |-> !dout_oe); // R7
  AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    commit |-> (wr_en_n && $past(!wr_en_n))); // R6
  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (rst)
    commit |=> cells[cgm_pkg::slot_of(int'($past(addr)), ROW_BITS, COL_BITS)]
               == $past(din)); // R3
  AST_FAULT_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    addr_fault |-> (!sel_n && !wr_en_n && $past(!sel_n && !wr_en_n))); // R8
endmodule

bind cell_grid_mem cgm_checker #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .rd_en_n(rd_en_n), .wr_en_n(wr_en_n),
  .addr(addr), .din(din), .dout_oe(dout_oe), .addr_fault(addr_fault),
  .commit(commit), .row_line(row_line), .cells(cells)
);

// File: tb/cell_grid_mem_test.sv
module cell_grid_mem_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b1, rd_en_n = 1'b1, wr_en_n = 1'b1;
  logic [3:0] addr = '0;
  logic       din = 1'b0;
  logic       dout, dout_oe, addr_fault;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  logic [15:0] model = '0;

  always #5 clk = ~clk;

  cell_grid_mem uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rd_en_n(rd_en_n), .wr_en_n(wr_en_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .addr_fault(addr_fault)
  );

  task automatic check(string req, string what, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic write_cell(int a, bit d);
    @(negedge clk);
    addr = 4'(a); din = d; sel_n = 0; rd_en_n = 1; wr_en_n = 0;
    @(negedge clk);
    wr_en_n = 1;
    @(negedge clk);
    sel_n = 1;
    model[a] = d;
  endtask

  task automatic read_check(string req, int a);
    @(negedge clk);
    addr = 4'(a); sel_n = 0; rd_en_n = 0; wr_en_n = 1;
    #1;
    check(req, $sformatf("dout_oe @%0d", a), int'(dout_oe), 1);
    check(req, $sformatf("dout @%0d", a), int'(dout), int'(model[a]));
  endtask

  // Expected bit of fill pattern k at address a.
  function automatic bit pat(int k, int a);
    case (k)
      0: return 1'b1;
      1: return ^(4'(a));        // checkerboard over row and column
      2: return a[0];            // row bit only
      default: return a[3];      // column bit only
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check("R1", "dout_oe after reset", int'(dout_oe), 0);
    for (int a = 0; a < 16; a++) read_check("R1", a);

    // R3 R9: fills that separate row and column bits
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 16; a++) write_cell(a, pat(k, a));
      for (int a = 0; a < 16; a++) read_check("R3", a);
    end

    // R2 R9: walking one finds aliased cells
    for (int w = 0; w < 16; w++) begin
      for (int a = 0; a < 16; a++) write_cell(a, a == w);
      for (int a = 0; a < 16; a++) read_check("R2", a);
    end

    // R4: deselected pulse stores nothing and drives nothing
    @(negedge clk);
    addr = 4'd5; din = 1; sel_n = 1; rd_en_n = 0; wr_en_n = 0;
    #1 check("R4", "dout_oe deselected", int'(dout_oe), 0);
    @(negedge clk); wr_en_n = 1;
    @(negedge clk);
    read_check("R4", 5);
    // R4: chip select leaves before write enable rises
    @(negedge clk);
    addr = 4'd6; din = 1; sel_n = 0; rd_en_n = 1; wr_en_n = 0;
    @(negedge clk); sel_n = 1;
    @(negedge clk); wr_en_n = 1;
    read_check("R4", 6);

    // R5: output enable high blocks the driver
    @(negedge clk);
    addr = 4'd0; sel_n = 0; rd_en_n = 1; wr_en_n = 1;
    #1 check("R5", "dout_oe with rd_en_n high", int'(dout_oe), 0);
    check("R5", "dout with rd_en_n high", int'(dout), 0);

    // R6: value at the rising edge is the one stored; R7 during pulse
    @(negedge clk);
    addr = 4'd9; din = 0; sel_n = 0; rd_en_n = 0; wr_en_n = 0;
    #1 check("R7", "dout_oe during write", int'(dout_oe), 0);
    @(negedge clk); din = 1;
    #1 check("R8", "fault with steady address", int'(addr_fault), 0);
    @(negedge clk); wr_en_n = 1; rd_en_n = 1;
    @(negedge clk); sel_n = 1;
    model[9] = 1;
    read_check("R6", 9);

    // R8: address moves inside a pulse; the final address is written
    @(negedge clk);
    addr = 4'd2; din = 1; sel_n = 0; rd_en_n = 1; wr_en_n = 0;
    #1 check("R8", "fault on first pulse cycle", int'(addr_fault), 0);
    @(negedge clk); addr = 4'd14;
    #1 check("R8", "fault on moved address", int'(addr_fault), 1);
    @(negedge clk); wr_en_n = 1;
    #1 check("R8", "fault after pulse", int'(addr_fault), 0);
    @(negedge clk); sel_n = 1;
    model[14] = 1;
    read_check("R6", 14);
    read_check("R8", 2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule